// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Controller

This block is a clocked model and controller for a byte-wide static RAM that has a nonvolatile shadow copy. It decodes four active-low control pins into SRAM reads and writes: chip enable, output enable, write enable and hardware store request/busy. The data bus is split into an input half, an output half and an output-enable strobe, which the pad ring merges into one shared I/O bus. Read data is registered, so it appears one clock after a valid read is decoded.

Besides normal SRAM mode, the block has a transfer mode with two operations. A STORE is requested by pulling the store pin low while idle. It first erases the shadow array and then copies the SRAM into it. A RECALL copies the shadow array back into the SRAM. A power-fail input stands in for supply sensing. While it is high, a RECALL request is held pending, and the RECALL starts by itself once power is good again. During either transfer, and while power is failing, every SRAM read and write is refused and `busy` is high for the whole transfer.

The address width is a parameter. It defaults to 10 bits so that elaboration stays small; the full 8K x 8 part uses `ADDR_W = 13`. The transfer lengths are given in clock cycles. They are raised if needed so that each sweep fits: one word per cycle, and two sweeps for a STORE.

Top module: `nvsram_top`

## Requirements
- R1: A read is decoded when ceN=0, oeN=0, weN=1, hsbN=1 in SRAM mode. On the next clock, dqOut carries the byte at addr and dqOutEn is 1.
- R2: A write is decoded when ceN=0, weN=0, hsbN=1 in SRAM mode, whatever oeN is. dqIn is stored at addr on that clock.
- R3: dqOutEn is 0 in any cycle in which weN is 0, even if oeN is 0 and a read was being driven.
- R4: While a read continues at an unchanged address, dqOut holds the same value on every cycle.
- R5: hsbN=0 in SRAM mode, with power good and no RECALL pending, starts a STORE. busy rises on the next clock and stays high for exactly max(STORE_CYCLES, 2*2^ADDR_W) cycles.
- R6: After a STORE, the shadow array holds the SRAM contents as they were when the STORE began. A later RECALL brings those values back even if the SRAM was overwritten in between.
- R7: While pwrFail is 1, a RECALL request is latched and no transfer starts. A read attempt leaves dqOutEn at 0.
- R8: When pwrFail returns to 0 with a RECALL pending, a RECALL starts on the next clock. busy stays high for exactly max(RESTORE_CYCLES, 2^ADDR_W) cycles, and afterwards every SRAM word equals its shadow word.
- R9: While busy is 1, write attempts leave the SRAM unchanged and read attempts leave dqOutEn at 0. A write pattern with hsbN=0 is not a write.
- R10: After reset, busy is 0 and dqOutEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| hsbN | input | 1 | Store request; must be high for reads and writes |
| pwrFail | input | 1 | High while the supply is below the safe level |
| addr | input | ADDR_W | Byte address |
| dqIn | input | DATA_W | Write data from the shared bus |
| dqOut | output | DATA_W | Read data toward the shared bus |
| dqOutEn | output | 1 | Drive enable for dqOut onto the shared bus |
| busy | output | 1 | High for the whole STORE or RECALL |

## Verification
The assertions assume that the control pins are sampled synchronously and that hsbN is released after a single request cycle, so a STORE is not re-armed when it completes. They also assume that pwrFail changes only while the block is idle or already failing. The directed tasks change every pin on the falling clock edge, hold hsbN low for exactly one cycle, and raise pwrFail only after `busy` has dropped. The RECALL check reads back only addresses written before the STORE, because shadow words that were never stored have no defined value.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [1:0] {
    MODE_SRAM   = 2'd0,
    MODE_STORE  = 2'd1,
    MODE_RECALL = 2'd2
  } nvMode_e;

  // strobes from the control unit into the array datapath
  typedef struct packed {
    logic rdEn;      // registered read of the SRAM word at addr
    logic wrEn;      // write dqIn into the SRAM word at addr
    logic eraseEn;   // set shadow word at sweep address to all ones
    logic progEn;    // copy SRAM word into shadow word at sweep address
    logic recallEn;  // copy shadow word into SRAM word at sweep address
  } nvStrobe_t;

endpackage

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int STORE_CYCLES   = 2056,
  parameter int RESTORE_CYCLES = 1032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hsbN,
  input  logic              pwrFail,
  output nvStrobe_t         strb,
  output logic [ADDR_W-1:0] sweepAddr,
  output logic              busy
);

  localparam int DEPTH       = 1 << ADDR_W;
  localparam int STORE_LEN   = (STORE_CYCLES   > 2 * DEPTH) ? STORE_CYCLES   : 2 * DEPTH;
  localparam int RESTORE_LEN = (RESTORE_CYCLES > DEPTH)     ? RESTORE_CYCLES : DEPTH;
  localparam int MAX_LEN     = (STORE_LEN > RESTORE_LEN) ? STORE_LEN : RESTORE_LEN;
  localparam int CNT_W       = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] STORE_LAST   = CNT_W'(STORE_LEN - 1);
  localparam logic [CNT_W-1:0] RESTORE_LAST = CNT_W'(RESTORE_LEN - 1);
  localparam logic [CNT_W-1:0] SWEEP_ONE    = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] SWEEP_TWO    = CNT_W'(2 * DEPTH);

  nvMode_e          mode;
  logic [CNT_W-1:0] cnt;
  logic             recallPend;
  logic             inSram;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode       <= MODE_SRAM;
      cnt        <= '0;
      recallPend <= 1'b0;
    end else begin
      if (pwrFail) recallPend <= 1'b1;
      unique case (mode)
        MODE_SRAM: begin
          cnt <= '0;
          if (!pwrFail && recallPend) begin
            mode       <= MODE_RECALL;
            recallPend <= 1'b0;
          end else if (!pwrFail && !hsbN) begin
            mode <= MODE_STORE;
          end
        end
        MODE_STORE: begin
          cnt <= cnt + 1'b1;
          if (cnt == STORE_LAST) mode <= MODE_SRAM;
        end
        MODE_RECALL: begin
          cnt <= cnt + 1'b1;
          if (cnt == RESTORE_LAST) mode <= MODE_SRAM;
        end
        default: mode <= MODE_SRAM;
      endcase
    end
  end

  // SRAM access only in SRAM mode with power good and reset released
  assign inSram = rstN && (mode == MODE_SRAM) && !pwrFail;

  always_comb begin
    strb          = '0;
    strb.rdEn     = inSram && !ceN && !oeN && weN && hsbN;
    strb.wrEn     = inSram && !ceN && !weN && hsbN;
    strb.eraseEn  = (mode == MODE_STORE) && (cnt < SWEEP_ONE);
    strb.progEn   = (mode == MODE_STORE) && (cnt >= SWEEP_ONE) && (cnt < SWEEP_TWO);
    strb.recallEn = (mode == MODE_RECALL) && (cnt < SWEEP_ONE);
  end

  // depth is a power of two, so the low bits serve both sweeps of a STORE
  assign sweepAddr = cnt[ADDR_W-1:0];
  assign busy      = (mode != MODE_SRAM);

  p_pend_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> recallPend);

  p_recall_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SRAM && recallPend && !pwrFail) |=> (mode == MODE_RECALL));

  p_store_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SRAM && !recallPend && !pwrFail && !hsbN) |=> (mode == MODE_STORE));

  p_one_sweep_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.eraseEn, strb.progEn, strb.recallEn, strb.wrEn}));

endmodule

// File: rtl/nvsram_dp.sv
module nvsram_dp
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvStrobe_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] sweepAddr,
  input  logic [DATA_W-1:0] dqIn,
  input  logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              dqOutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sramMem [DEPTH];
  logic [DATA_W-1:0] nvMem   [DEPTH];
  logic              rdValid;

  always_ff @(posedge clk) begin
    if (strb.wrEn)          sramMem[addr]      <= dqIn;
    else if (strb.recallEn) sramMem[sweepAddr] <= nvMem[sweepAddr];
    if (strb.eraseEn)       nvMem[sweepAddr]   <= '1;
    else if (strb.progEn)   nvMem[sweepAddr]   <= sramMem[sweepAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= sramMem[addr];
    end
  end

  // drive only while the registered read is still being requested
  assign dqOutEn = rdValid && strb.rdEn;

  p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> rdValid);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && $past(strb.rdEn) && addr == $past(addr)) |=> (rdData == $past(rdData)));

  p_no_access_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.rdEn || strb.wrEn));

endmodule

// File: rtl/nvsram_top.sv
module nvsram_top
  import nvsram_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int DATA_W         = 8,
  parameter int STORE_CYCLES   = 2056,
  parameter int RESTORE_CYCLES = 1032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hsbN,
  input  logic              pwrFail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOutEn,
  output logic              busy
);

  nvStrobe_t         strb;
  logic [ADDR_W-1:0] sweepAddr;

  nvsram_ctrl #(
    .ADDR_W(ADDR_W), .STORE_CYCLES(STORE_CYCLES), .RESTORE_CYCLES(RESTORE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .hsbN(hsbN),
    .pwrFail(pwrFail), .strb(strb), .sweepAddr(sweepAddr), .busy(busy)
  );

  nvsram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .sweepAddr(sweepAddr),
    .dqIn(dqIn), .busy(busy), .rdData(dqOut), .dqOutEn(dqOutEn)
  );

  p_tristate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !dqOutEn);

  p_pwr_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> !(strb.rdEn || strb.wrEn));

endmodule

// File: tb/tb_nvsram_top.sv
module tb_nvsram_top;

  localparam int ADDR_W      = 10;
  localparam int DATA_W      = 8;
  localparam int STORE_CYC   = 2056;
  localparam int RESTORE_CYC = 1032;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int STORE_EXP   = (STORE_CYC > 2 * DEPTH) ? STORE_CYC : 2 * DEPTH;
  localparam int RESTORE_EXP = (RESTORE_CYC > DEPTH) ? RESTORE_CYC : DEPTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, hsbN = 1'b1, pwrFail = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dqIn = '0;
  logic [DATA_W-1:0] dqOut;
  logic dqOutEn, busy;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  nvsram_top #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_CYCLES(STORE_CYC), .RESTORE_CYCLES(RESTORE_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .hsbN(hsbN),
    .pwrFail(pwrFail), .addr(addr), .dqIn(dqIn), .dqOut(dqOut),
    .dqOutEn(dqOutEn), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idlePins();
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1; hsbN = 1'b1;
  endtask

  task automatic writeByte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic oe);
    ceN = 1'b0; weN = 1'b0; oeN = oe; addr = a; dqIn = d;
    @(negedge clk);
    idlePins();
  endtask

  task automatic readByte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                          input string req);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a;
    @(negedge clk);
    check(dqOutEn == 1'b1, req, dqOutEn, 1);
    check(dqOut == exp, req, dqOut, exp);
    idlePins();
    @(negedge clk);
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R10 busy", busy, 0);
    check(dqOutEn == 1'b0, "R10 dqOutEn", dqOutEn, 0);
  endtask

  task automatic testReadWrite();
    writeByte(10'h000, 8'h11, 1'b1);
    writeByte(10'h001, 8'h22, 1'b1);
    writeByte(10'h3FF, 8'h33, 1'b0);   // R2 with oeN low
    writeByte(10'h007, 8'h44, 1'b1);
    writeByte(10'h005, 8'h55, 1'b0);
    readByte(10'h000, 8'h11, "R1 addr0");
    readByte(10'h001, 8'h22, "R1 addr1");
    readByte(10'h3FF, 8'h33, "R2 oeN low write");
    readByte(10'h005, 8'h55, "R2 addr5");
    ceN = 1'b0; oeN = 1'b0; addr = 10'h007;
    #1 check(dqOutEn == 1'b0, "R1 no data before a clock", dqOutEn, 0);
    @(negedge clk);
    idlePins();
    @(negedge clk);
  endtask

  task automatic testTristate();
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = 10'h001;
    @(negedge clk);
    check(dqOutEn == 1'b1, "R3 driving before write", dqOutEn, 1);
    weN = 1'b0; dqIn = 8'h66;
    #1 check(dqOutEn == 1'b0, "R3 off once weN low", dqOutEn, 0);
    @(negedge clk);
    check(dqOutEn == 1'b0, "R3 off during write", dqOutEn, 0);
    idlePins();
    @(negedge clk);
    readByte(10'h001, 8'h66, "R3 write with oeN low landed");
    writeByte(10'h001, 8'h22, 1'b1);
  endtask

  task automatic testHold();
    logic [DATA_W-1:0] first;
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = 10'h007;
    @(negedge clk);
    first = dqOut;
    check(first == 8'h44, "R4 first", first, 8'h44);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(dqOut == first && dqOutEn, "R4 held", dqOut, first);
    end
    addr = 10'h3FF;
    @(negedge clk);
    check(dqOut == 8'h33, "R4 new address", dqOut, 8'h33);
    idlePins();
    @(negedge clk);
  endtask

  task automatic testStore();
    int count;
    // write pattern together with hsbN low: a STORE request, not a write (R9)
    ceN = 1'b0; weN = 1'b0; hsbN = 1'b0; addr = 10'h007; dqIn = 8'h99;
    @(negedge clk);
    idlePins();
    check(busy == 1'b1, "R5 busy after request", busy, 1);
    count = 0;
    while (busy && count < 100000) begin
      if (count == 3) begin ceN = 1'b0; weN = 1'b0; addr = 10'h005; dqIn = 8'hEE; end
      if (count == 4) begin weN = 1'b1; oeN = 1'b0; end
      if (count == 6) begin
        check(dqOutEn == 1'b0, "R9 no read while busy", dqOutEn, 0);
        idlePins();
      end
      count++;
      @(negedge clk);
    end
    check(count == STORE_EXP, "R5 store length", count, STORE_EXP);
    readByte(10'h005, 8'h55, "R9 write during busy ignored");
    readByte(10'h007, 8'h44, "R9 write with hsbN low ignored");
  endtask

  task automatic testRecall();
    int count;
    writeByte(10'h000, 8'hA0, 1'b1);
    writeByte(10'h001, 8'hA1, 1'b1);
    writeByte(10'h3FF, 8'hA2, 1'b1);
    readByte(10'h000, 8'hA0, "R6 overwrite visible");
    pwrFail = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(busy == 1'b0, "R7 no transfer while failing", busy, 0);
    end
    ceN = 1'b0; oeN = 1'b0; addr = 10'h001;
    @(negedge clk);
    check(dqOutEn == 1'b0, "R7 read refused", dqOutEn, 0);
    idlePins();
    @(negedge clk);
    pwrFail = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R8 recall started", busy, 1);
    count = 0;
    while (busy && count < 100000) begin
      count++;
      @(negedge clk);
    end
    check(count == RESTORE_EXP, "R8 restore length", count, RESTORE_EXP);
    readByte(10'h000, 8'h11, "R6 R8 addr0 restored");
    readByte(10'h001, 8'h22, "R6 R8 addr1 restored");
    readByte(10'h3FF, 8'h33, "R6 R8 top restored");
    readByte(10'h005, 8'h55, "R8 addr5 restored");
  endtask

  initial begin
    #(8 * 200000);
    nErr++;
    nChecks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReadWrite();
    testTristate();
    testHold();
    testStore();
    testRecall();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule